// File: doc/BRIEF.md
# Shared DRAM Cycle Sequencer

This block turns a 16 MHz master clock into the repeating sixteen-step timing frame that lets a Z80 CPU and a video controller take turns on one bank of dynamic RAM. Each master clock advances a four-bit step counter by one, and the counter wraps after step 15. Steps 0 to 7 belong to the video controller and steps 8 to 15 belong to the CPU.

From the step count the block produces a set of fixed-phase outputs, which do not depend on any input. These are the 4 MHz CPU clock, the CRTC clock (which also serves as video address bit zero), the CPU/video address-mux select (also a 1 MHz sound-chip clock), the row/column mux select, the row strobe, and a wait/latch strobe for the CPU.

During the CPU half the block also produces three conditional strobes, each gated by the Z80 bus controls sampled on each master clock. These are the column strobe, a write enable inferred from a memory request without a read, and an enable for the bridge between the CPU and video data buses. All outputs come from registers, so they change only on clock edges and carry no glitches.

Top module: `memcyc_seq`

## Requirements
- R1: While `rst_n` is low at a rising edge, the step counter returns to 0 and every output reads 1 after that edge. After release, the k-th rising edge puts the block in step k mod 16, and all outputs reflect that step.
- R2: The step advances by one on every master clock and wraps from 15 to 0. `phi_o` is 1 in steps whose bit 1 is set (2,3,6,7,10,11,14,15) and 0 otherwise, giving four periods per frame.
- R3: `crtc_clk_o` is 0 in steps 0–7 and 1 in steps 8–15. `addr_sel_n_o` is the inverse: 1 in steps 0–7 (video) and 0 in steps 8–15 (CPU).
- R4: `ras_n_o` is 0 in steps 1–5 and 9–13 and 1 elsewhere, whatever the bus inputs.
- R5: `col_sel_o` is 1 (column address) in steps 2–7 and 10–15, and 0 (row address) in steps 0, 1, 8 and 9.
- R6: `cas_n_o` is 0 in steps 3–5 on every frame, whatever the bus inputs.
- R7: In steps 11–13, `cas_n_o` is 0 exactly when `mreq_n` was 0 at the edge entering that step. In steps 6–10 and 14–15 it is 1.
- R8: `we_n_o` is 0 only in steps 11–13, and only when `mreq_n` was 0 and `rd_n` was 1 at the edge entering that step. It is 1 at all other times.
- R9: `bus_bridge_n_o` is 0 only in steps 9–14, exactly when `iorq_n` was 0 at the edge entering that step. `rd_n` and `mreq_n` have no effect on it.
- R10: `ready_n_o` is 0 in steps 12–15 and 1 in steps 0–11 on every frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 16 MHz master clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mreq_n | input | 1 | CPU memory request, active low |
| rd_n | input | 1 | CPU read, active low |
| iorq_n | input | 1 | CPU I/O request, active low |
| phi_o | output | 1 | 4 MHz CPU clock |
| crtc_clk_o | output | 1 | CRTC clock and video address bit zero |
| addr_sel_n_o | output | 1 | Address mux select, 0 = CPU address; 1 MHz sound clock |
| col_sel_o | output | 1 | Row/column mux select, 1 = column |
| ras_n_o | output | 1 | DRAM row strobe, active low |
| cas_n_o | output | 1 | DRAM column strobe, active low |
| we_n_o | output | 1 | DRAM write enable, active low |
| bus_bridge_n_o | output | 1 | CPU-to-video data bus bridge enable, active low |
| ready_n_o | output | 1 | CPU wait and read-data latch strobe, active low |

## Verification
Two pairs of functions can fall in the same cycle. A CPU memory write drives the column strobe and the write enable together in steps 11–13. A request that holds `mreq_n` and `iorq_n` low at once drives the bridge enable across those same steps. The bench provokes both, including inputs that change from one step to the next, and compares every output on every step with a model built from the step lists above. This shows that each conditional strobe follows only its own inputs and that the fixed outputs are undisturbed.

// File: rtl/memcyc_seq.sv
module memcyc_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic mreq_n,
  input  logic rd_n,
  input  logic iorq_n,
  output logic phi_o,
  output logic crtc_clk_o,
  output logic addr_sel_n_o,
  output logic col_sel_o,
  output logic ras_n_o,
  output logic cas_n_o,
  output logic we_n_o,
  output logic bus_bridge_n_o,
  output logic ready_n_o
);

  localparam int StepW = 4;

  logic [StepW-1:0] step_q;
  logic [StepW-1:0] step_d;
  logic             cpu_win;
  logic [StepW-2:0] sub;
  logic             mid_win;

  assign step_d  = step_q + 1'b1;
  assign cpu_win = step_d[StepW-1];
  assign sub     = step_d[StepW-2:0];
  assign mid_win = (sub >= 3'd3) && (sub <= 3'd5);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step_q         <= '0;
      phi_o          <= 1'b1;
      crtc_clk_o     <= 1'b1;
      addr_sel_n_o   <= 1'b1;
      col_sel_o      <= 1'b1;
      ras_n_o        <= 1'b1;
      cas_n_o        <= 1'b1;
      we_n_o         <= 1'b1;
      bus_bridge_n_o <= 1'b1;
      ready_n_o      <= 1'b1;
    end else begin
      step_q         <= step_d;
      phi_o          <= step_d[1];
      crtc_clk_o     <= cpu_win;
      addr_sel_n_o   <= ~cpu_win;
      col_sel_o      <= (sub >= 3'd2);
      ras_n_o        <= ~((sub >= 3'd1) && (sub <= 3'd5));
      cas_n_o        <= ~(mid_win && (!cpu_win || !mreq_n));
      we_n_o         <= ~(mid_win && cpu_win && !mreq_n && rd_n);
      bus_bridge_n_o <= ~(cpu_win && (sub >= 3'd1) && (sub <= 3'd6) && !iorq_n);
      ready_n_o      <= ~(cpu_win && (sub >= 3'd4));
    end
  end

  // R2
  step_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_q == 4'd15) |=> (step_q == 4'd0));

  // R8
  we_in_cpu_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n_o |-> (!cas_n_o && crtc_clk_o && !ras_n_o));

  // R9
  bridge_in_cpu_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_bridge_n_o |-> (crtc_clk_o && !addr_sel_n_o));

  // R5
  ras_on_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n_o) |-> !col_sel_o);

  // R10
  ready_in_cpu_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_n_o |-> !addr_sel_n_o);

  // R7
  cas_under_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n_o |-> (!ras_n_o && col_sel_o));

endmodule

// File: tb/memcyc_seq_tb.sv
module memcyc_seq_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mreq_n = 1'b1, rd_n = 1'b1, iorq_n = 1'b1;
  logic phi_o, crtc_clk_o, addr_sel_n_o, col_sel_o, ras_n_o;
  logic cas_n_o, we_n_o, bus_bridge_n_o, ready_n_o;

  int vectors = 0;
  int errors = 0;
  int step = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  memcyc_seq u_dut (
    .clk(clk), .rst_n(rst_n), .mreq_n(mreq_n), .rd_n(rd_n), .iorq_n(iorq_n),
    .phi_o(phi_o), .crtc_clk_o(crtc_clk_o), .addr_sel_n_o(addr_sel_n_o),
    .col_sel_o(col_sel_o), .ras_n_o(ras_n_o), .cas_n_o(cas_n_o),
    .we_n_o(we_n_o), .bus_bridge_n_o(bus_bridge_n_o), .ready_n_o(ready_n_o)
  );

  task automatic chk(string tag, logic act, logic exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s step %0d: actual %b expected %b", tag, step, act, exp);
    end
  endtask

  function automatic bit in_list(int s, int lo, int hi);
    return (s >= lo) && (s <= hi);
  endfunction

  task automatic check_step(logic m, logic r, logic i);
    chk("R2 phi", phi_o, (step % 4) >= 2);
    chk("R3 crtc_clk", crtc_clk_o, step >= 8);
    chk("R3 addr_sel_n", addr_sel_n_o, step < 8);
    chk("R4 ras_n", ras_n_o, !(in_list(step, 1, 5) || in_list(step, 9, 13)));
    chk("R5 col_sel", col_sel_o, in_list(step, 2, 7) || in_list(step, 10, 15));
    chk("R6/R7 cas_n", cas_n_o, !(in_list(step, 3, 5) || (in_list(step, 11, 13) && !m)));
    chk("R8 we_n", we_n_o, !(in_list(step, 11, 13) && !m && r));
    chk("R9 bridge_n", bus_bridge_n_o, !(in_list(step, 9, 14) && !i));
    chk("R10 ready_n", ready_n_o, !in_list(step, 12, 15));
  endtask

  task automatic tick(logic m, logic r, logic i);
    mreq_n = m; rd_n = r; iorq_n = i;
    @(posedge clk);
    step = (step + 1) % 16;
    @(negedge clk);
    check_step(m, r, i);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    mreq_n = 1'b0; rd_n = 1'b1; iorq_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    step = 0;
    chk("R1 phi", phi_o, 1'b1);
    chk("R1 crtc", crtc_clk_o, 1'b1);
    chk("R1 addr_sel", addr_sel_n_o, 1'b1);
    chk("R1 col_sel", col_sel_o, 1'b1);
    chk("R1 ras", ras_n_o, 1'b1);
    chk("R1 cas", cas_n_o, 1'b1);
    chk("R1 we", we_n_o, 1'b1);
    chk("R1 bridge", bus_bridge_n_o, 1'b1);
    chk("R1 ready", ready_n_o, 1'b1);
    rst_n = 1'b1;
    tick(1, 1, 1);
    chk("R1 first step", ras_n_o, 1'b0);
  endtask

  task automatic t_idle();
    for (int k = 0; k < 48; k++) tick(1, 1, 1);
  endtask

  task automatic t_mem_read();
    for (int k = 0; k < 32; k++) tick(0, 0, 1);
  endtask

  task automatic t_mem_write();
    for (int k = 0; k < 32; k++) tick(0, 1, 1);
  endtask

  task automatic t_io();
    for (int k = 0; k < 16; k++) tick(1, 0, 0);
    for (int k = 0; k < 16; k++) tick(1, 1, 0);
    for (int k = 0; k < 16; k++) tick(0, 1, 0);
  endtask

  task automatic t_toggling();
    for (int k = 0; k < 64; k++) tick(logic'(k[0]), logic'(k[1]), logic'(k[2]));
  endtask

  task automatic t_reset_midframe();
    while (step != 7) tick(0, 1, 0);
    t_reset();
    for (int k = 0; k < 20; k++) tick(0, 1, 0);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_idle();
    t_mem_read();
    t_mem_write();
    t_io();
    t_toggling();
    t_reset_midframe();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule